// File: doc/BRIEF.md
# Segment Bank Selector and Blink Controller

This block sits between the display RAM read port and the segment output drivers of a low-multiplex LCD driver. It takes the RAM word fetched for a segment and the current backplane phase. From these it picks the single bit that the segment shows in that phase. The choice depends on the drive mode (static or 1:2 multiplex) and on which RAM bank is selected for display. A 4-bit write lane mask comes out alongside. It tells the RAM write path which bits of a word belong to the bank that incoming data is written into.

The block also applies blinking. A one-cycle tick from a slow timebase is divided down to three blink rates with a 50% duty cycle. A rate code of zero turns blinking off. Normal blinking blanks every segment during the second half of each blink period. Alternation blinking keeps the segments lit and swaps the displayed bank on each half period. Each blink period starts with its shown half. The divider starts again from that shown half whenever the rate code changes.

Top module: `lcd_seg_blink`

## Requirements
- R1: With `blink_rate` = 1, 2 or 3, the blink state changes after HALF_TICKS, 2*HALF_TICKS or 4*HALF_TICKS ticks respectively, so each half period is equally long.
- R2: With `blink_rate` = 0 no blinking occurs: ticks have no effect and the bank named by `bank_out_sel` is always shown.
- R3: In normal blink mode (`blink_alt` = 0), `seg_bit` is 0 during the blanked half. During the shown half it is the selected RAM bit. Each period begins with the shown half.
- R4: In alternation mode (`blink_alt` = 1), the shown half displays bank `bank_out_sel` and the other half displays the opposite bank; nothing is blanked.
- R5: In static mode (`mux2_mode` = 0), bank 0 shows `ram_word[0]` and bank 1 shows `ram_word[2]`, whatever `bp_phase` is.
- R6: In 1:2 multiplex mode (`mux2_mode` = 1), bank b shows `ram_word[2b]` when `bp_phase` = 0 and `ram_word[2b+1]` when `bp_phase` = 1.
- R7: `wr_mask` is 4'b0001 or 4'b0100 in static mode and 4'b0011 or 4'b1100 in 1:2 mode, for `bank_in_sel` = 0 or 1. Display bank selection does not affect it.
- R8: A change of `blink_rate` clears the tick count and returns to the shown half on the next clock edge; the new rate is counted from zero.
- R9: After reset the blink state is in its shown half with a zero tick count.
- R10: Between ticks the blink state holds, however many clocks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| blink_rate | input | 2 | Blink rate code: 0 off, 1 fastest, 2 half that, 3 quarter |
| blink_alt | input | 1 | 0 normal (blanking) blink, 1 alternation blink |
| bank_in_sel | input | 1 | Bank that incoming display data is written into |
| bank_out_sel | input | 1 | Bank that is displayed |
| mux2_mode | input | 1 | 0 static drive, 1 1:2 multiplex |
| bp_phase | input | 1 | Current backplane phase index |
| ram_word | input | 4 | RAM bits read for this segment |
| seg_bit | output | 1 | Segment data for the current phase |
| wr_mask | output | 4 | RAM bit lanes owned by the write bank |

## Verification
The bench walks all sixteen RAM words through both banks, both phases and both modes, so that a swapped bit index or a static mode that follows the backplane phase shows up as a wrong `seg_bit`. Each rate is driven one tick short of its half period and then one tick onto it. A divider off by one or a doubled rate would flip early or late. A rate change part way through a count must not flip on the next tick, and it must bring a blanked display back. A design that kept its old count or phase would blank too soon or stay dark. Alternation is checked against a blank-only design, and a long idle between ticks catches a divider that counts clocks.

// File: rtl/seg_blink_pkg.sv
// Shared encodings for the segment bank and blink controller.
// Assumes the rate code is two bits wide, with zero meaning "off".
package seg_blink_pkg;
    typedef enum logic [1:0] {
        RATE_OFF  = 2'd0,
        RATE_FAST = 2'd1,
        RATE_MID  = 2'd2,
        RATE_SLOW = 2'd3
    } blink_rate_e;

    localparam int RAM_BITS = 4;
endpackage

// File: rtl/blink_divider.sv
// Divides the slow timebase tick into a 50% duty blink state.
// Assumes tick is a single-cycle pulse. Half period = HALF_TICKS scaled
// by 1, 2 or 4 with the rate code. Any rate change, or rate off, restarts
// in the shown half (phase 0) with a zero count.
module blink_divider
    import seg_blink_pkg::*;
#(
    parameter int HALF_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] rate,
    output logic       phase
);
    localparam int MAX_HALF = 4 * HALF_TICKS;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [1:0]       rate_q;
    logic             phase_q;

    // Half-period length in ticks for the current rate code.
    always_comb begin
        case (blink_rate_e'(rate))
            RATE_FAST: limit = CNT_W'(HALF_TICKS);
            RATE_MID:  limit = CNT_W'(2 * HALF_TICKS);
            RATE_SLOW: limit = CNT_W'(4 * HALF_TICKS);
            default:   limit = CNT_W'(HALF_TICKS);
        endcase
    end

    // Tick counting, half-period toggling and restart on rate change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            rate_q  <= '0;
        end else begin
            rate_q <= rate;
            if (rate == RATE_OFF || rate != rate_q) begin
                cnt_q   <= '0;
                phase_q <= 1'b0;
            end else if (tick) begin
                if (cnt_q >= limit - CNT_W'(1)) begin
                    cnt_q   <= '0;
                    phase_q <= ~phase_q;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/bank_bit_picker.sv
// Picks the displayed RAM bit for a bank, drive mode and backplane phase.
// Assumes bank b owns lanes 2b and 2b+1. Static mode uses only lane 2b.
module bank_bit_picker
    import seg_blink_pkg::*;
(
    input  logic                bank,
    input  logic                mux2,
    input  logic                bp,
    input  logic [RAM_BITS-1:0] word,
    output logic                bit_out
);
    logic [1:0] lane;

    // Lane index: bank picks the pair, phase picks within it in 1:2 mode.
    always_comb begin
        lane    = {bank, mux2 & bp};
        bit_out = word[lane];
    end
endmodule

// File: rtl/wr_mask_gen.sv
// Marks the RAM lanes owned by the bank chosen for incoming data.
// Assumes the same lane layout as the bit picker.
module wr_mask_gen
    import seg_blink_pkg::*;
(
    input  logic                bank,
    input  logic                mux2,
    output logic [RAM_BITS-1:0] mask
);
    logic [1:0] pair;

    // One lane in static mode, two in 1:2 mode, shifted to the bank's pair.
    always_comb begin
        pair = mux2 ? 2'b11 : 2'b01;
        mask = bank ? {pair, 2'b00} : {2'b00, pair};
    end
endmodule

// File: rtl/lcd_seg_blink.sv
// Top of the segment bank and blink controller.
// Combines the blink state with the display bank select. Normal blink
// blanks the second half; alternation inverts the bank instead.
// Assumes ram_word is already the word for the segment being driven.
module lcd_seg_blink
    import seg_blink_pkg::*;
#(
    parameter int HALF_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] blink_rate,
    input  logic       blink_alt,
    input  logic       bank_in_sel,
    input  logic       bank_out_sel,
    input  logic       mux2_mode,
    input  logic       bp_phase,
    input  logic [3:0] ram_word,
    output logic       seg_bit,
    output logic [3:0] wr_mask
);
    logic blink_phase;
    logic show_bank;
    logic picked;

    blink_divider #(.HALF_TICKS(HALF_TICKS)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rate  (blink_rate),
        .phase (blink_phase)
    );

    // Alternation swaps the bank in the second half.
    always_comb show_bank = bank_out_sel ^ (blink_alt & blink_phase);

    bank_bit_picker pick_i (
        .bank    (show_bank),
        .mux2    (mux2_mode),
        .bp      (bp_phase),
        .word    (ram_word),
        .bit_out (picked)
    );

    // Normal blink forces the segment off in the second half.
    always_comb seg_bit = picked & ~(~blink_alt & blink_phase);

    wr_mask_gen wm_i (
        .bank (bank_in_sel),
        .mux2 (mux2_mode),
        .mask (wr_mask)
    );
endmodule

// File: rtl/seg_blink_chk.sv
// Property checker for lcd_seg_blink, attached through bind.
module seg_blink_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] blink_rate,
    input logic       blink_alt,
    input logic       mux2_mode,
    input logic       seg_bit,
    input logic [3:0] wr_mask,
    input logic       blink_phase
);
    // R2: with blinking off the blink state sits in the shown half
    p_off_shown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_rate == 2'd0) |=> !blink_phase);

    // R8: a rate change returns to the shown half
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_rate != $past(blink_rate)) |=> !blink_phase);

    // R3: normal blink blanks the segment in the second half
    p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blink_alt && blink_phase) |-> !seg_bit);

    // R7: lane count follows the drive mode
    p_mask_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_mask) == (mux2_mode ? 2 : 1));

    // R10: without a tick and with a steady rate the blink state holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && blink_rate == $past(blink_rate)) |=> $stable(blink_phase));
endmodule

bind lcd_seg_blink seg_blink_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .blink_rate  (blink_rate),
    .blink_alt   (blink_alt),
    .mux2_mode   (mux2_mode),
    .seg_bit     (seg_bit),
    .wr_mask     (wr_mask),
    .blink_phase (blink_phase)
);

// File: tb/lcd_seg_blink_tb_top.sv
// Directed bench for lcd_seg_blink: one task per scenario.
module lcd_seg_blink_tb_top;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] blink_rate = 2'd0;
    logic       blink_alt = 1'b0;
    logic       bank_in_sel = 1'b0;
    logic       bank_out_sel = 1'b0;
    logic       mux2_mode = 1'b0;
    logic       bp_phase = 1'b0;
    logic [3:0] ram_word = 4'b0000;
    logic       seg_bit;
    logic [3:0] wr_mask;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lcd_seg_blink #(.HALF_TICKS(HALF)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .blink_rate   (blink_rate),
        .blink_alt    (blink_alt),
        .bank_in_sel  (bank_in_sel),
        .bank_out_sel (bank_out_sel),
        .mux2_mode    (mux2_mode),
        .bp_phase     (bp_phase),
        .ram_word     (ram_word),
        .seg_bit      (seg_bit),
        .wr_mask      (wr_mask)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic set_rate(input logic [1:0] r);
        @(negedge clk) blink_rate = r;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Expected displayed bit from R5/R6.
    function automatic logic exp_bit(input logic [3:0] w, input logic b,
                                     input logic m, input logic p);
        if (!m) return b ? w[2] : w[0];
        return w[{b, p}];
    endfunction

    task automatic t_reset;
        ram_word = 4'b0001;
        @(negedge clk);
        check("R9", {3'b0, seg_bit}, 4'b0001);
        check("R7", wr_mask, 4'b0001);
    endtask

    task automatic t_mapping;
        for (int m = 0; m < 2; m++)
            for (int w = 0; w < 16; w++)
                for (int b = 0; b < 2; b++)
                    for (int p = 0; p < 2; p++) begin
                        mux2_mode = m[0]; ram_word = w[3:0];
                        bank_out_sel = b[0]; bp_phase = p[0];
                        #1;
                        check(m ? "R6" : "R5", {3'b0, seg_bit},
                              {3'b0, exp_bit(w[3:0], b[0], m[0], p[0])});
                    end
        mux2_mode = 1'b0; bank_out_sel = 1'b0; bp_phase = 1'b0;
    endtask

    task automatic t_wr_mask;
        for (int m = 0; m < 2; m++)
            for (int b = 0; b < 2; b++)
                for (int o = 0; o < 2; o++) begin
                    mux2_mode = m[0]; bank_in_sel = b[0]; bank_out_sel = o[0];
                    #1;
                    check("R7", wr_mask,
                          m ? (b ? 4'b1100 : 4'b0011) : (b ? 4'b0100 : 4'b0001));
                end
        mux2_mode = 1'b0; bank_in_sel = 1'b0; bank_out_sel = 1'b0;
    endtask

    task automatic t_normal_rates;
        ram_word = 4'b0001; blink_alt = 1'b0;
        for (int r = 1; r < 4; r++) begin
            int h = HALF << (r - 1);
            set_rate(r[1:0]);
            pulse_ticks(h - 1);
            check("R1", {3'b0, seg_bit}, 4'b0001);
            pulse_ticks(1);
            check("R3", {3'b0, seg_bit}, 4'b0000);
            pulse_ticks(h - 1);
            check("R1", {3'b0, seg_bit}, 4'b0000);
            pulse_ticks(1);
            check("R3", {3'b0, seg_bit}, 4'b0001);
        end
    endtask

    task automatic t_idle_hold;
        set_rate(2'd1);
        pulse_ticks(HALF);
        repeat (40) @(negedge clk);
        check("R10", {3'b0, seg_bit}, 4'b0000);
        pulse_ticks(HALF);
        repeat (40) @(negedge clk);
        check("R10", {3'b0, seg_bit}, 4'b0001);
    endtask

    task automatic t_alternate;
        set_rate(2'd0);
        ram_word = 4'b0100; blink_alt = 1'b1; bank_out_sel = 1'b0;
        set_rate(2'd1);
        check("R4", {3'b0, seg_bit}, 4'b0000);
        pulse_ticks(HALF);
        check("R4", {3'b0, seg_bit}, 4'b0001);
        mux2_mode = 1'b1; bp_phase = 1'b1; ram_word = 4'b0010;
        #1 check("R4", {3'b0, seg_bit}, 4'b0000);
        pulse_ticks(HALF);
        check("R4", {3'b0, seg_bit}, 4'b0001);
        mux2_mode = 1'b0; bp_phase = 1'b0;
    endtask

    task automatic t_off;
        blink_alt = 1'b1; ram_word = 4'b0100; bank_out_sel = 1'b1;
        set_rate(2'd0);
        pulse_ticks(9);
        check("R2", {3'b0, seg_bit}, 4'b0001);
        blink_alt = 1'b0; ram_word = 4'b0001; bank_out_sel = 1'b0;
        pulse_ticks(3);
        check("R2", {3'b0, seg_bit}, 4'b0001);
    endtask

    task automatic t_restart;
        blink_alt = 1'b0; ram_word = 4'b0001;
        set_rate(2'd2);
        pulse_ticks(2 * HALF - 1);
        set_rate(2'd1);
        pulse_ticks(1);
        check("R8", {3'b0, seg_bit}, 4'b0001);
        pulse_ticks(HALF - 1);
        check("R8", {3'b0, seg_bit}, 4'b0000);
        @(negedge clk) blink_rate = 2'd3;
        @(negedge clk);
        check("R8", {3'b0, seg_bit}, 4'b0001);
        set_rate(2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mapping();
        t_wr_mask();
        t_normal_rates();
        t_idle_hold();
        t_alternate();
        t_off();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule